// File: doc/BRIEF.md
# Two-Cycle Grouped Issue Scheduler

This block is an out-of-order issue queue whose scheduling loop is split over two clock cycles. Each queue entry carries a scheduling-unit ID and holds either one instruction or a fused pair of two dependent instructions. A fused pair counts as one scheduling unit. It is selected once and broadcasts its ID once. Its two instruction slots then leave on the same issue port in consecutive cycles. Because a selection in cycle n wakes dependents in cycle n+1, and they can be selected in cycle n+2, a fused pair still runs two dependent instructions back to back. A consumer of the pair follows the tail with no bubble.

An allocator inserts one entry per cycle. The entry carries its ID, an age, up to three source IDs with ready flags, and one or two instruction words. The third source belongs to the tail of a pair. A pair whose tail has not yet been inserted waits in its entry until a later fill supplies the tail. A flush removes every entry younger than a given age. Register access, execution and replay are handled elsewhere.

Top module: `gis_sched`

## Requirements
- R1: After reset, no entry is valid, `iq_full` is 0, and every `exe_valid` and `bc_valid` bit is 0.
- R2: A single-instruction entry whose sources are all ready is selected in the cycle after its insertion edge. Its instruction appears on an issue port at the next edge, with `exe_second` = 0.
- R3: A fused pair appears with its head (`exe_second` = 0) in one cycle and its tail (`exe_second` = 1) on the same port in the very next cycle.
- R4: A single producer's dependent reaches an issue port two cycles after the producer, leaving one idle cycle between them.
- R5: A fused pair's dependent reaches an issue port in the cycle right after the pair's tail.
- R6: Every selected entry raises `bc_valid` with its ID exactly once, on its port and in its head cycle. A pair raises nothing in its tail cycle.
- R7: An entry with an unready source is not selected until that source ID is broadcast. A source whose ID is broadcast in the cycle of its insertion is captured as ready.
- R8: A pair inserted without its tail (`ins_pair` = 1, `ins_tail_vld` = 0) is never selected. Once a fill with its ID arrives, the pair issues head then tail.
- R9: When more entries are ready than there are free ports, the entries with the lowest ages go first. Free ports are filled in index order, oldest on the lowest port.
- R10: Up to ISSUE_W entries issue per cycle. A port that is sending a pair's tail takes no new selection in that cycle, and the remaining free ports are still used.
- R11: With `flush_valid` = 1, every entry whose age is strictly greater than `flush_age` is removed, and older entries remain.
- R12: `iq_full` is 1 exactly when all DEPTH entries are valid. A pair, pending or complete, occupies a single entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert one entry this cycle |
| ins_uid | input | UID_W | Scheduling-unit ID of the new entry |
| ins_age | input | AGE_W | Age of the new entry (smaller is older) |
| ins_pair | input | 1 | Entry is a fused pair |
| ins_tail_vld | input | 1 | Tail of the pair is supplied with this insert |
| ins_head | input | INSTR_W | Head (or only) instruction word |
| ins_tail | input | INSTR_W | Tail instruction word |
| ins_src_tag | input | 3*UID_W | Source IDs; index 2 is the tail's extra source |
| ins_src_rdy | input | 3 | Source already ready |
| fill_valid | input | 1 | Deliver a late tail |
| fill_uid | input | UID_W | ID of the pending pair to complete |
| fill_tail | input | INSTR_W | Late tail instruction word |
| fill_src_tag | input | UID_W | Tail's extra source ID |
| fill_src_rdy | input | 1 | Tail's extra source already ready |
| flush_valid | input | 1 | Remove younger entries |
| flush_age | input | AGE_W | Entries with a greater age are removed |
| iq_full | output | 1 | All entries valid |
| exe_valid | output | ISSUE_W | Instruction on each issue port |
| exe_instr | output | ISSUE_W*INSTR_W | Instruction word per port |
| exe_uid | output | ISSUE_W*UID_W | Scheduling-unit ID per port |
| exe_second | output | ISSUE_W | Port carries the tail of a pair |
| bc_valid | output | ISSUE_W | ID broadcast per port |
| bc_uid | output | ISSUE_W*UID_W | Broadcast ID per port |

## Verification
A fixed set of lone single and paired entries shows the basic head/tail spacing and the single broadcast. Producer/consumer chains compare the one-cycle bubble after a single producer with the seamless hand-off after a pair. Insertion during a broadcast separates bypass capture from a stale ready flag. A burst of six consumers woken together by one producer, inserted in scrambled age order, separates oldest-first selection from arrival order. A mix with a pair tests port reuse while that pair's tail is out. A pending pair, a full queue and a partial flush then show that an entry without its tail stays put, that a pair takes one entry, and that only younger entries are removed.

// File: rtl/gis_pkg.sv
package gis_pkg;
    // Source operand slots per entry: two for the head, one extra for a tail
    localparam int NSRC     = 3;
    localparam int SRC_TAIL = 2;
endpackage

// File: rtl/gis_tag_match.sv
module gis_tag_match #(
    parameter int UID_W   = 4,
    parameter int ISSUE_W = 4
) (
    input  logic [UID_W-1:0]              tag,
    input  logic [ISSUE_W-1:0]            bc_valid,
    input  logic [ISSUE_W-1:0][UID_W-1:0] bc_uid,
    output logic                          hit
);
    logic [ISSUE_W-1:0] port_hit;

    for (genvar p = 0; p < ISSUE_W; p++) begin : g_port
        assign port_hit[p] = bc_valid[p] && (bc_uid[p] == tag);
    end

    assign hit = |port_hit;
endmodule

// File: rtl/gis_oldest_sel.sv
module gis_oldest_sel #(
    parameter int DEPTH   = 8,
    parameter int AGE_W   = 4,
    parameter int ISSUE_W = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]              ready,
    input  logic [DEPTH-1:0][AGE_W-1:0]   age,
    input  logic [ISSUE_W-1:0]            port_free,
    output logic [ISSUE_W-1:0]            gnt_v,
    output logic [ISSUE_W-1:0][IDX_W-1:0] gnt_idx
);
    logic [DEPTH-1:0] taken;
    logic             found;
    logic [IDX_W-1:0] best;

    // Ports are served in index order; each takes the oldest remaining ready entry.
    always_comb begin
        taken   = '0;
        gnt_v   = '0;
        gnt_idx = '0;
        found   = 1'b0;
        best    = '0;
        for (int p = 0; p < ISSUE_W; p++) begin
            found = 1'b0;
            best  = '0;
            if (port_free[p]) begin
                for (int e = 0; e < DEPTH; e++) begin
                    if (ready[e] && !taken[e] && (!found || (age[e] < age[best]))) begin
                        found = 1'b1;
                        best  = IDX_W'(e);
                    end
                end
            end
            gnt_v[p]   = found;
            gnt_idx[p] = best;
            if (found) taken[best] = 1'b1;
        end
    end
endmodule

// File: rtl/gis_issue_port.sv
module gis_issue_port #(
    parameter int UID_W   = 4,
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gnt_v,
    input  logic               gnt_pair,
    input  logic [UID_W-1:0]   gnt_uid,
    input  logic [INSTR_W-1:0] gnt_head,
    input  logic [INSTR_W-1:0] gnt_tail,
    output logic               busy,
    output logic               exe_valid,
    output logic [INSTR_W-1:0] exe_instr,
    output logic [UID_W-1:0]   exe_uid,
    output logic               exe_second,
    output logic               bc_valid,
    output logic [UID_W-1:0]   bc_uid
);
    typedef struct packed {
        logic               exe_v;
        logic [INSTR_W-1:0] exe_instr;
        logic [UID_W-1:0]   exe_uid;
        logic               exe_second;
        logic               bc_v;
        logic [UID_W-1:0]   bc_uid;
        logic               tail_pend;
        logic [INSTR_W-1:0] tail_instr;
        logic [UID_W-1:0]   tail_uid;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d            = port_q;
        port_d.exe_v      = 1'b0;
        port_d.exe_second = 1'b0;
        port_d.bc_v       = 1'b0;
        port_d.tail_pend  = 1'b0;
        if (port_q.tail_pend) begin
            // second cycle of a pair: tail goes out, no broadcast
            port_d.exe_v      = 1'b1;
            port_d.exe_instr  = port_q.tail_instr;
            port_d.exe_uid    = port_q.tail_uid;
            port_d.exe_second = 1'b1;
        end else if (gnt_v) begin
            port_d.exe_v     = 1'b1;
            port_d.exe_instr = gnt_head;
            port_d.exe_uid   = gnt_uid;
            port_d.bc_v      = 1'b1;
            port_d.bc_uid    = gnt_uid;
            if (gnt_pair) begin
                port_d.tail_pend  = 1'b1;
                port_d.tail_instr = gnt_tail;
                port_d.tail_uid   = gnt_uid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign busy       = port_q.tail_pend;
    assign exe_valid  = port_q.exe_v;
    assign exe_instr  = port_q.exe_instr;
    assign exe_uid    = port_q.exe_uid;
    assign exe_second = port_q.exe_second;
    assign bc_valid   = port_q.bc_v;
    assign bc_uid     = port_q.bc_uid;

    // R10
    busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !gnt_v);
    // R6
    bc_on_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_v |=> (bc_valid && exe_valid && !exe_second && bc_uid == $past(gnt_uid)));
    // R3
    pair_tail_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_v && gnt_pair) |=> ##1 (exe_valid && exe_second && !bc_valid));
endmodule

// File: rtl/gis_sched.sv
module gis_sched
    import gis_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 4,
    parameter int UID_W   = 4,
    parameter int AGE_W   = 4,
    parameter int INSTR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ins_valid,
    input  logic [UID_W-1:0]                ins_uid,
    input  logic [AGE_W-1:0]                ins_age,
    input  logic                            ins_pair,
    input  logic                            ins_tail_vld,
    input  logic [INSTR_W-1:0]              ins_head,
    input  logic [INSTR_W-1:0]              ins_tail,
    input  logic [NSRC-1:0][UID_W-1:0]      ins_src_tag,
    input  logic [NSRC-1:0]                 ins_src_rdy,
    input  logic                            fill_valid,
    input  logic [UID_W-1:0]                fill_uid,
    input  logic [INSTR_W-1:0]              fill_tail,
    input  logic [UID_W-1:0]                fill_src_tag,
    input  logic                            fill_src_rdy,
    input  logic                            flush_valid,
    input  logic [AGE_W-1:0]                flush_age,
    output logic                            iq_full,
    output logic [ISSUE_W-1:0]              exe_valid,
    output logic [ISSUE_W-1:0][INSTR_W-1:0] exe_instr,
    output logic [ISSUE_W-1:0][UID_W-1:0]   exe_uid,
    output logic [ISSUE_W-1:0]              exe_second,
    output logic [ISSUE_W-1:0]              bc_valid,
    output logic [ISSUE_W-1:0][UID_W-1:0]   bc_uid
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic                       valid;
        logic                       pending;
        logic                       pair;
        logic [UID_W-1:0]           uid;
        logic [AGE_W-1:0]           age;
        logic [INSTR_W-1:0]         head;
        logic [INSTR_W-1:0]         tail;
        logic [NSRC-1:0][UID_W-1:0] src;
        logic [NSRC-1:0]            rdy;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } iq_t;

    iq_t iq_d, iq_q;

    logic [DEPTH-1:0]              ent_ready;
    logic [DEPTH-1:0][AGE_W-1:0]   ent_age;
    logic [DEPTH-1:0][NSRC-1:0]    ent_hit;
    logic [NSRC-1:0]               ins_hit;
    logic                          fill_hit;
    logic [ISSUE_W-1:0]            port_busy;
    logic [ISSUE_W-1:0]            gnt_v;
    logic [ISSUE_W-1:0][IDX_W-1:0] gnt_idx;
    logic                          free_v;
    logic [IDX_W-1:0]              free_idx;

    // ---------------- wakeup: compare every source against the broadcast bus
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            gis_tag_match #(.UID_W(UID_W), .ISSUE_W(ISSUE_W)) u_match (
                .tag      (iq_q.ent[e].src[s]),
                .bc_valid (bc_valid),
                .bc_uid   (bc_uid),
                .hit      (ent_hit[e][s])
            );
        end
        assign ent_ready[e] = iq_q.ent[e].valid && !iq_q.ent[e].pending && (&iq_q.ent[e].rdy);
        assign ent_age[e]   = iq_q.ent[e].age;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_ins_src
        gis_tag_match #(.UID_W(UID_W), .ISSUE_W(ISSUE_W)) u_ins_match (
            .tag      (ins_src_tag[s]),
            .bc_valid (bc_valid),
            .bc_uid   (bc_uid),
            .hit      (ins_hit[s])
        );
    end

    gis_tag_match #(.UID_W(UID_W), .ISSUE_W(ISSUE_W)) u_fill_match (
        .tag      (fill_src_tag),
        .bc_valid (bc_valid),
        .bc_uid   (bc_uid),
        .hit      (fill_hit)
    );

    // ---------------- select
    gis_oldest_sel #(.DEPTH(DEPTH), .AGE_W(AGE_W), .ISSUE_W(ISSUE_W)) u_sel (
        .ready     (ent_ready),
        .age       (ent_age),
        .port_free (~port_busy),
        .gnt_v     (gnt_v),
        .gnt_idx   (gnt_idx)
    );

    // ---------------- issue ports with dual-slot payload sequencing
    for (genvar p = 0; p < ISSUE_W; p++) begin : g_port
        gis_issue_port #(.UID_W(UID_W), .INSTR_W(INSTR_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .gnt_v      (gnt_v[p]),
            .gnt_pair   (iq_q.ent[gnt_idx[p]].pair),
            .gnt_uid    (iq_q.ent[gnt_idx[p]].uid),
            .gnt_head   (iq_q.ent[gnt_idx[p]].head),
            .gnt_tail   (iq_q.ent[gnt_idx[p]].tail),
            .busy       (port_busy[p]),
            .exe_valid  (exe_valid[p]),
            .exe_instr  (exe_instr[p]),
            .exe_uid    (exe_uid[p]),
            .exe_second (exe_second[p]),
            .bc_valid   (bc_valid[p]),
            .bc_uid     (bc_uid[p])
        );
    end

    // ---------------- free slot search (lowest invalid index)
    always_comb begin
        free_v   = 1'b0;
        free_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (!iq_q.ent[e].valid) begin
                free_v   = 1'b1;
                free_idx = IDX_W'(e);
            end
        end
    end

    assign iq_full = !free_v;

    // ---------------- next state
    always_comb begin
        iq_d = iq_q;
        for (int e = 0; e < DEPTH; e++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (ent_hit[e][s]) iq_d.ent[e].rdy[s] = 1'b1;
            end
            if (fill_valid && iq_q.ent[e].valid && iq_q.ent[e].pending &&
                iq_q.ent[e].uid == fill_uid) begin
                iq_d.ent[e].tail           = fill_tail;
                iq_d.ent[e].src[SRC_TAIL]  = fill_src_tag;
                iq_d.ent[e].rdy[SRC_TAIL]  = fill_src_rdy || fill_hit;
                iq_d.ent[e].pending        = 1'b0;
            end
            if (flush_valid && iq_q.ent[e].valid && iq_q.ent[e].age > flush_age)
                iq_d.ent[e].valid = 1'b0;
        end
        for (int p = 0; p < ISSUE_W; p++) begin
            if (gnt_v[p]) iq_d.ent[gnt_idx[p]].valid = 1'b0;
        end
        if (ins_valid && free_v && !(flush_valid && ins_age > flush_age)) begin
            iq_d.ent[free_idx].valid   = 1'b1;
            iq_d.ent[free_idx].pending = ins_pair && !ins_tail_vld;
            iq_d.ent[free_idx].pair    = ins_pair;
            iq_d.ent[free_idx].uid     = ins_uid;
            iq_d.ent[free_idx].age     = ins_age;
            iq_d.ent[free_idx].head    = ins_head;
            iq_d.ent[free_idx].tail    = ins_tail;
            iq_d.ent[free_idx].src     = ins_src_tag;
            for (int s = 0; s < NSRC; s++)
                iq_d.ent[free_idx].rdy[s] = ins_src_rdy[s] || ins_hit[s];
            // the extra source only matters for a pair
            if (!ins_pair) iq_d.ent[free_idx].rdy[SRC_TAIL] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) iq_q <= '0;
        else        iq_q <= iq_d;
    end

    // ---------------- checks
    for (genvar p = 0; p < ISSUE_W; p++) begin : g_port_chk
        // R8
        no_pending_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_v[p] |-> (iq_q.ent[gnt_idx[p]].valid && !iq_q.ent[gnt_idx[p]].pending));
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent_chk
        // R11
        flush_young_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush_valid |=> !(iq_q.ent[e].valid && iq_q.ent[e].age > $past(flush_age)));
    end
endmodule

// File: tb/gis_sched_tb.sv
module gis_sched_tb;
    import gis_pkg::*;

    localparam int DEPTH   = 8;
    localparam int ISSUE_W = 4;
    localparam int UID_W   = 4;
    localparam int AGE_W   = 4;
    localparam int INSTR_W = 16;

    logic                            clk = 1'b0;
    logic                            rst_n = 1'b0;
    logic                            ins_valid;
    logic [UID_W-1:0]                ins_uid;
    logic [AGE_W-1:0]                ins_age;
    logic                            ins_pair;
    logic                            ins_tail_vld;
    logic [INSTR_W-1:0]              ins_head;
    logic [INSTR_W-1:0]              ins_tail;
    logic [NSRC-1:0][UID_W-1:0]      ins_src_tag;
    logic [NSRC-1:0]                 ins_src_rdy;
    logic                            fill_valid;
    logic [UID_W-1:0]                fill_uid;
    logic [INSTR_W-1:0]              fill_tail;
    logic [UID_W-1:0]                fill_src_tag;
    logic                            fill_src_rdy;
    logic                            flush_valid;
    logic [AGE_W-1:0]                flush_age;
    logic                            iq_full;
    logic [ISSUE_W-1:0]              exe_valid;
    logic [ISSUE_W-1:0][INSTR_W-1:0] exe_instr;
    logic [ISSUE_W-1:0][UID_W-1:0]   exe_uid;
    logic [ISSUE_W-1:0]              exe_second;
    logic [ISSUE_W-1:0]              bc_valid;
    logic [ISSUE_W-1:0][UID_W-1:0]   bc_uid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    gis_sched #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .UID_W(UID_W),
                .AGE_W(AGE_W), .INSTR_W(INSTR_W)) u_dut (
        .clk, .rst_n, .ins_valid, .ins_uid, .ins_age, .ins_pair, .ins_tail_vld,
        .ins_head, .ins_tail, .ins_src_tag, .ins_src_rdy, .fill_valid, .fill_uid,
        .fill_tail, .fill_src_tag, .fill_src_rdy, .flush_valid, .flush_age,
        .iq_full, .exe_valid, .exe_instr, .exe_uid, .exe_second, .bc_valid, .bc_uid
    );

    // stimulus table: {pair, head word, tail word}
    localparam int NV = 4;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 16'h1111, 16'h0000},
        {1'b1, 16'h2222, 16'h2223},
        {1'b0, 16'h3333, 16'h0000},
        {1'b1, 16'h4444, 16'h4445}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clr_in();
        ins_valid = 0; ins_uid = '0; ins_age = '0; ins_pair = 0; ins_tail_vld = 0;
        ins_head = '0; ins_tail = '0; ins_src_tag = '0; ins_src_rdy = '1;
        fill_valid = 0; fill_uid = '0; fill_tail = '0; fill_src_tag = '0; fill_src_rdy = 1;
        flush_valid = 0; flush_age = '0;
    endtask

    task automatic put(input logic [UID_W-1:0] uid, input logic [AGE_W-1:0] age,
                       input logic pair, input logic tvld,
                       input logic [INSTR_W-1:0] head, input logic [INSTR_W-1:0] tail,
                       input logic [UID_W-1:0] src0, input logic rdy0);
        ins_valid = 1; ins_uid = uid; ins_age = age; ins_pair = pair; ins_tail_vld = tvld;
        ins_head = head; ins_tail = tail;
        ins_src_tag = '0; ins_src_tag[0] = src0;
        ins_src_rdy = '1; ins_src_rdy[0] = rdy0;
    endtask

    task automatic chk_port(input string req, input int p, input logic v,
                            input logic [INSTR_W-1:0] instr, input logic second,
                            input logic bcv);
        checks++;
        if (exe_valid[p] !== v || bc_valid[p] !== bcv ||
            (v && (exe_instr[p] !== instr || exe_second[p] !== second))) begin
            errors++;
            $display("FAIL %s port%0d: got v=%b instr=%h sec=%b bc=%b, expected v=%b instr=%h sec=%b bc=%b",
                     req, p, exe_valid[p], exe_instr[p], exe_second[p], bc_valid[p],
                     v, instr, second, bcv);
        end
    endtask

    task automatic chk_idle(input string req);
        checks++;
        if (exe_valid !== '0 || bc_valid !== '0) begin
            errors++;
            $display("FAIL %s: got exe=%b bc=%b, expected exe=0000 bc=0000", req, exe_valid, bc_valid);
        end
    endtask

    task automatic chk_full(input string req, input logic exp);
        checks++;
        if (iq_full !== exp) begin
            errors++;
            $display("FAIL %s: got iq_full=%b, expected %b", req, iq_full, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R1 reset state
        chk_full("R1", 1'b0);
        chk_idle("R1");

        // R2 R3 R6 table walk: single or pair alone
        for (int i = 0; i < NV; i++) begin
            put(UID_W'(i + 1), AGE_W'(i), VEC[i][32], 1'b1, VEC[i][31:16], VEC[i][15:0], '0, 1'b1);
            tick(); clr_in();
            tick();
            chk_port("R2/R6 head", 0, 1'b1, VEC[i][31:16], 1'b0, 1'b1);
            checks++;
            if (bc_uid[0] !== UID_W'(i + 1)) begin
                errors++;
                $display("FAIL R6: got bc_uid=%0d, expected %0d", bc_uid[0], i + 1);
            end
            tick();
            if (VEC[i][32]) chk_port("R3/R6 tail", 0, 1'b1, VEC[i][15:0], 1'b1, 1'b0);
            else            chk_idle("R2 single done");
            tick();
        end

        // R4 single producer -> dependent with one bubble
        put(4'd2, 4'd2, 0, 1, 16'hC004, '0, 4'd1, 1'b0); tick();
        put(4'd1, 4'd1, 0, 1, 16'hA004, '0, 4'd0, 1'b1); tick(); clr_in();
        tick(); chk_port("R4 producer", 0, 1'b1, 16'hA004, 1'b0, 1'b1);
        tick(); chk_idle("R4/R7 bubble");
        tick(); chk_port("R4 dependent", 0, 1'b1, 16'hC004, 1'b0, 1'b1);
        tick();

        // R5 pair producer -> dependent right after tail
        put(4'd4, 4'd2, 0, 1, 16'hC005, '0, 4'd3, 1'b0); tick();
        put(4'd3, 4'd1, 1, 1, 16'hA005, 16'hB005, 4'd0, 1'b1); tick(); clr_in();
        tick(); chk_port("R5 head", 0, 1'b1, 16'hA005, 1'b0, 1'b1);
        tick(); chk_port("R5 tail", 0, 1'b1, 16'hB005, 1'b1, 1'b0);
        tick(); chk_port("R5 dependent", 0, 1'b1, 16'hC005, 1'b0, 1'b1);
        tick();

        // R7 bypass: insert while producer's ID is on the bus
        put(4'd6, 4'd1, 0, 1, 16'hA007, '0, 4'd0, 1'b1); tick(); clr_in();
        tick(); chk_port("R7 producer", 0, 1'b1, 16'hA007, 1'b0, 1'b1);
        put(4'd7, 4'd2, 0, 1, 16'hC007, '0, 4'd6, 1'b0); tick(); clr_in();
        tick(); chk_port("R7 bypass consumer", 0, 1'b1, 16'hC007, 1'b0, 1'b1);
        tick();

        // R9 oldest-first over six woken consumers
        begin
            int ages [6] = '{5, 3, 6, 1, 4, 2};
            for (int i = 0; i < 6; i++) begin
                put(UID_W'(10 + i), AGE_W'(ages[i]), 0, 1, INSTR_W'(16'h0100 + ages[i]), '0, 4'd9, 1'b0);
                tick();
            end
        end
        put(4'd9, 4'd7, 0, 1, 16'hA009, '0, 4'd0, 1'b1); tick(); clr_in();
        chk_full("R12 seven entries", 1'b0);
        tick(); chk_port("R9 producer", 0, 1'b1, 16'hA009, 1'b0, 1'b1);
        tick(); chk_idle("R9 wake cycle");
        tick();
        for (int p = 0; p < 4; p++)
            chk_port("R9 oldest four", p, 1'b1, INSTR_W'(16'h0101 + p), 1'b0, 1'b1);
        tick();
        chk_port("R9 next oldest", 0, 1'b1, 16'h0105, 1'b0, 1'b1);
        chk_port("R9 next oldest", 1, 1'b1, 16'h0106, 1'b0, 1'b1);
        chk_port("R9 spare port", 2, 1'b0, '0, 1'b0, 1'b0);
        tick();

        // R10 port held by a pair's tail
        put(4'd1, 4'd1, 1, 1, 16'h0201, 16'h0211, 4'd9, 1'b0); tick();
        for (int i = 2; i <= 5; i++) begin
            put(UID_W'(i), AGE_W'(i), 0, 1, INSTR_W'(16'h0200 + i), '0, 4'd9, 1'b0);
            tick();
        end
        put(4'd9, 4'd6, 0, 1, 16'hA010, '0, 4'd0, 1'b1); tick(); clr_in();
        tick(); chk_port("R10 producer", 0, 1'b1, 16'hA010, 1'b0, 1'b1);
        tick(); tick();
        chk_port("R10 pair head", 0, 1'b1, 16'h0201, 1'b0, 1'b1);
        for (int p = 1; p < 4; p++)
            chk_port("R10 full width", p, 1'b1, INSTR_W'(16'h0201 + p), 1'b0, 1'b1);
        tick();
        chk_port("R10 tail holds port", 0, 1'b1, 16'h0211, 1'b1, 1'b0);
        chk_port("R10 free port reused", 1, 1'b1, 16'h0205, 1'b0, 1'b1);
        chk_port("R10 idle port", 2, 1'b0, '0, 1'b0, 1'b0);
        tick();

        // R8 pending pair waits for late tail
        put(4'd5, 4'd1, 1, 0, 16'h0301, '0, 4'd0, 1'b1); tick(); clr_in();
        for (int i = 0; i < 3; i++) begin tick(); chk_idle("R8 pending held"); end
        fill_valid = 1; fill_uid = 4'd5; fill_tail = 16'h0302; fill_src_tag = '0; fill_src_rdy = 1;
        tick(); clr_in();
        tick(); chk_port("R8 head after fill", 0, 1'b1, 16'h0301, 1'b0, 1'b1);
        tick(); chk_port("R8 tail after fill", 0, 1'b1, 16'h0302, 1'b1, 1'b0);
        tick();

        // R12 full with a pending pair; R11 partial flush
        for (int i = 1; i <= 7; i++) begin
            put(UID_W'(i), AGE_W'(i), 0, 1, INSTR_W'(16'h0400 + i), '0, 4'd15, 1'b0);
            tick();
        end
        put(4'd8, 4'd8, 1, 0, 16'h0408, '0, 4'd0, 1'b1); tick(); clr_in();
        chk_full("R12 full with pending pair", 1'b1);
        chk_idle("R7 waiting entries stay");
        flush_valid = 1; flush_age = 4'd3; tick(); clr_in();
        chk_full("R11 flush freed entries", 1'b0);
        put(4'd15, 4'd0, 0, 1, 16'hA011, '0, 4'd0, 1'b1); tick(); clr_in();
        tick(); chk_port("R11 producer", 0, 1'b1, 16'hA011, 1'b0, 1'b1);
        tick(); tick();
        for (int p = 0; p < 3; p++)
            chk_port("R11 older kept", p, 1'b1, INSTR_W'(16'h0401 + p), 1'b0, 1'b1);
        chk_port("R11 younger gone", 3, 1'b0, '0, 1'b0, 1'b0);
        tick(); chk_idle("R11 nothing left");
        tick(); chk_idle("R11 nothing left later");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule